// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the register file that software programs a four-channel DMA engine through. It sits on an 8-bit I/O bus with a 4-bit port offset. Each channel has a 16-bit start address and a 16-bit transfer count. Both are reached through byte-wide ports. One shared byte-pointer bit decides whether an access hits the low byte or the high byte. The count is loaded as the number of transfers minus one.

Beside the per-channel pairs, the block holds:
- one mode field per channel
- a mask bit per channel
- a control word
- a software request nibble
- a sticky terminal-count nibble, which is read through the status port

Strobe ports reset the byte pointer and perform a master clear.

The transfer engine pulses a per-channel advance input once per transfer. On each pulse the block steps the current address up or down, and decrements the current count. When the count wraps from zero, the channel has reached terminal count. The block flags it in status and, if autoinitialize is selected, reloads the current registers from the base copies.

Top module: `legacy_dma_regs`

## Requirements
- R1: After reset all four mask bits are 1, every base/current address and count is 0x0000, every mode field and the control word are 0, status reads 0x00, and the byte pointer selects the low byte.
- R2: Each read or write at offsets 0..7 flips the byte pointer: the first access hits bits 7:0 and the next hits bits 15:8. A write of any value to offset 0xC returns the pointer to low.
- R3: Channel n (0..3) has its address at offset 2n and its count at offset 2n+1. A write loads the selected byte into both the base and the current copy. A read returns the selected byte of the current value.
- R4: A write to offset 0xA sets the mask bit of channel wdata[1:0] to wdata[2]. A write to 0xE clears all mask bits. A write to 0xF loads the mask bits from wdata[3:0].
- R5: A write to offset 0xB stores wdata[7:2] as the 6-bit mode field of channel wdata[1:0]. Field bit 2 (byte bit 4) selects autoinitialize. Field bit 3 (byte bit 5) selects address decrement.
- R6: An advance pulse on an unmasked channel steps the current address by +1, or by -1 when decrement is selected, and lowers the current count by 1.
- R7: An advance pulse on a masked channel leaves its current address and count unchanged.
- R8: Terminal count occurs on an advance when the current count is 0x0000. The count then becomes 0xFFFF and status bit n is set. The status port (read at offset 8) returns {request[3:0], tc[3:0]}, and a status read clears the tc bits.
- R9: With autoinitialize selected, terminal count reloads the current address and count from their base copies.
- R10: A write to offset 9 sets the request bit of channel wdata[1:0] to wdata[2]. Request bits appear in status bits 7:4.
- R11: A write to offset 0xD (master clear) has these effects:
  - sets all mask bits
  - resets the byte pointer to low
  - clears the tc and request bits
  - clears the control word
  - leaves the modes and the address and count registers unchanged
- R12: A write to offset 8 stores the byte as the control word. A read at offset 0xD returns 0x00.
- R13: When a bus write to a channel's address or count port coincides with an advance on that channel, the write takes effect and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data for the current offset |
| advance | input | 4 | Per-channel transfer-done pulse |
| chan_mode | output | 24 | Mode fields, channel n at bits 6n+5:6n |
| chan_mask | output | 4 | Mask bit per channel |
| ctl_word | output | 8 | Control word |
| cur_addr | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_count | output | 64 | Current counts, channel n at bits 16n+15:16n |

## Verification
The byte pointer is driven with paired writes, with a stray single write followed by a pointer reset, and with reads interleaved with writes. This separates a pointer that toggles on every 16-bit access from one that toggles only on writes or never re-aligns.

The advance path is tried in four settings:
- incrementing and decrementing modes
- on a masked channel
- across the zero wrap with and without autoinitialize
- in the same cycle as a bus load

Together these distinguish step direction, mask gating, reload versus wrap, and write priority.

Status is read twice after a terminal count, and again after a request write and a master clear. This shows the read-to-clear behaviour and how the two nibbles are packed.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NCH    = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = BYTE_W - 2;
  localparam int OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_CMD   = 4'h8;
  localparam logic [OFF_W-1:0] OFF_REQ   = 4'h9;
  localparam logic [OFF_W-1:0] OFF_SMASK = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE  = 4'hB;
  localparam logic [OFF_W-1:0] OFF_PCLR  = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 4'hD;
  localparam logic [OFF_W-1:0] OFF_UNALL = 4'hE;
  localparam logic [OFF_W-1:0] OFF_AMASK = 4'hF;

  localparam int MODE_AUTO_BIT = 2;
  localparam int MODE_DEC_BIT  = 3;

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input logic dec);
    return dec ? WORD_W'(a - 1'b1) : WORD_W'(a + 1'b1);
  endfunction

  function automatic logic [WORD_W-1:0] dec_count(input logic [WORD_W-1:0] c);
    return WORD_W'(c - 1'b1);
  endfunction

  function automatic logic is_word_port(input logic [OFF_W-1:0] off);
    return !off[OFF_W-1];
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_lo,
  input  logic              a_wr_hi,
  input  logic              c_wr_lo,
  input  logic              c_wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              advance,
  input  logic              masked,
  input  logic              autoinit,
  input  logic              decrement,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt,
  output logic              tc_hit
);
  logic [WORD_W-1:0] base_addr, base_cnt;
  logic any_load, step_ok;

  assign any_load = a_wr_lo | a_wr_hi | c_wr_lo | c_wr_hi;
  assign step_ok  = advance && !masked && !any_load;
  assign tc_hit   = step_ok && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (any_load) begin
      if (a_wr_lo) begin
        base_addr[BYTE_W-1:0] <= wdata;
        cur_addr[BYTE_W-1:0]  <= wdata;
      end
      if (a_wr_hi) begin
        base_addr[WORD_W-1:BYTE_W] <= wdata;
        cur_addr[WORD_W-1:BYTE_W]  <= wdata;
      end
      if (c_wr_lo) begin
        base_cnt[BYTE_W-1:0] <= wdata;
        cur_cnt[BYTE_W-1:0]  <= wdata;
      end
      if (c_wr_hi) begin
        base_cnt[WORD_W-1:BYTE_W] <= wdata;
        cur_cnt[WORD_W-1:BYTE_W]  <= wdata;
      end
    end else if (step_ok) begin
      if (tc_hit && autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= step_addr(cur_addr, decrement);
        cur_cnt  <= dec_count(cur_cnt);
      end
    end
  end

  // R6
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !tc_hit) |=> cur_cnt == WORD_W'($past(cur_cnt) - 1'b1));

  // R7
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && masked && !any_load) |=> ($stable(cur_addr) && $stable(cur_cnt)));

  // R8
  tc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && !autoinit) |=> cur_cnt == '1);

  // R9
  tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit && autoinit) |=> (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr)));

  // R13
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && c_wr_lo) |=> cur_cnt[BYTE_W-1:0] == $past(wdata));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OFF_W-1:0]      bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [NCH-1:0]        tc_hit,
  output logic                  ptr_hi,
  output logic [NCH-1:0]        mask_q,
  output logic [NCH*MODE_W-1:0] mode_flat,
  output logic [BYTE_W-1:0]     cmd_q,
  output logic [BYTE_W-1:0]     status
);
  logic [NCH-1:0] req_q, tc_q;
  logic acc16, mclr, pclr, rd_stat;
  logic wr_cmd, wr_req, wr_smask, wr_mode, wr_unall, wr_amask;
  logic [1:0] sel;

  assign sel      = bus_wdata[1:0];
  assign acc16    = (bus_wr || bus_rd) && is_word_port(bus_addr);
  assign mclr     = bus_wr && bus_addr == OFF_MCLR;
  assign pclr     = bus_wr && bus_addr == OFF_PCLR;
  assign rd_stat  = bus_rd && bus_addr == OFF_CMD;
  assign wr_cmd   = bus_wr && bus_addr == OFF_CMD;
  assign wr_req   = bus_wr && bus_addr == OFF_REQ;
  assign wr_smask = bus_wr && bus_addr == OFF_SMASK;
  assign wr_mode  = bus_wr && bus_addr == OFF_MODE;
  assign wr_unall = bus_wr && bus_addr == OFF_UNALL;
  assign wr_amask = bus_wr && bus_addr == OFF_AMASK;
  assign status   = {req_q, tc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi <= 1'b0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else if (mclr) begin
      ptr_hi <= 1'b0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      if (pclr)       ptr_hi <= 1'b0;
      else if (acc16) ptr_hi <= !ptr_hi;
      if (wr_smask)      mask_q[sel] <= bus_wdata[2];
      else if (wr_unall) mask_q <= '0;
      else if (wr_amask) mask_q <= bus_wdata[NCH-1:0];
      if (wr_req) req_q[sel] <= bus_wdata[2];
      if (wr_cmd) cmd_q <= bus_wdata;
      tc_q <= (rd_stat ? '0 : tc_q) | tc_hit;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mode
    logic [MODE_W-1:0] mode_r;
    always_ff @(posedge clk) begin
      if (!rst_n)                      mode_r <= '0;
      else if (wr_mode && sel == 2'(i)) mode_r <= bus_wdata[BYTE_W-1:2];
    end
    assign mode_flat[i*MODE_W +: MODE_W] = mode_r;
  end

  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclr |=> !ptr_hi);

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc16 && !mclr) |=> ptr_hi != $past(ptr_hi));

  // R4
  mask_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_smask |=> mask_q[$past(sel)] == $past(bus_wdata[2]));

  // R8
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_hit && !mclr) |=> (tc_q & $past(tc_hit)) == $past(tc_hit));

  // R11
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1 && !ptr_hi && status == '0 && cmd_q == '0));
endmodule

// File: rtl/legacy_dma_regs.sv
module legacy_dma_regs
  import dma_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OFF_W-1:0]      bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]        advance,
  output logic [NCH*MODE_W-1:0] chan_mode,
  output logic [NCH-1:0]        chan_mask,
  output logic [BYTE_W-1:0]     ctl_word,
  output logic [NCH*WORD_W-1:0] cur_addr,
  output logic [NCH*WORD_W-1:0] cur_count
);
  logic ptr_hi;
  logic [NCH-1:0] tc_hit;
  logic [BYTE_W-1:0] status;
  logic word_wr;

  assign word_wr = bus_wr && is_word_port(bus_addr);

  dma_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .tc_hit(tc_hit), .ptr_hi(ptr_hi),
    .mask_q(chan_mask), .mode_flat(chan_mode), .cmd_q(ctl_word), .status(status)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel_ch, a_lo, a_hi, c_lo, c_hi;
    assign sel_ch = word_wr && bus_addr[2:1] == 2'(i);
    assign a_lo   = sel_ch && !bus_addr[0] && !ptr_hi;
    assign a_hi   = sel_ch && !bus_addr[0] &&  ptr_hi;
    assign c_lo   = sel_ch &&  bus_addr[0] && !ptr_hi;
    assign c_hi   = sel_ch &&  bus_addr[0] &&  ptr_hi;

    dma_chan_regs u_chan (
      .clk(clk), .rst_n(rst_n),
      .a_wr_lo(a_lo), .a_wr_hi(a_hi), .c_wr_lo(c_lo), .c_wr_hi(c_hi),
      .wdata(bus_wdata), .advance(advance[i]), .masked(chan_mask[i]),
      .autoinit(chan_mode[i*MODE_W + MODE_AUTO_BIT]),
      .decrement(chan_mode[i*MODE_W + MODE_DEC_BIT]),
      .cur_addr(cur_addr[i*WORD_W +: WORD_W]),
      .cur_cnt(cur_count[i*WORD_W +: WORD_W]),
      .tc_hit(tc_hit[i])
    );
  end

  always_comb begin
    logic [WORD_W-1:0] word;
    word      = bus_addr[0] ? cur_count[bus_addr[2:1]*WORD_W +: WORD_W]
                            : cur_addr[bus_addr[2:1]*WORD_W +: WORD_W];
    bus_rdata = '0;
    if (is_word_port(bus_addr))
      bus_rdata = ptr_hi ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
    else if (bus_addr == OFF_CMD)
      bus_rdata = status;
  end
endmodule

// File: tb/legacy_dma_regs_test.sv
module legacy_dma_regs_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] advance = 0;
  logic [7:0] bus_rdata, ctl_word;
  logic [23:0] chan_mode;
  logic [3:0] chan_mask;
  logic [63:0] cur_addr, cur_count;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  legacy_dma_regs uut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr8(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd8(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr16(logic [3:0] a, logic [15:0] v);
    wr8(a, v[7:0]); wr8(a, v[15:8]);
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); advance = m;
    @(negedge clk); advance = 0;
  endtask

  function automatic logic [15:0] ad(int n); return cur_addr[16*n +: 16]; endfunction
  function automatic logic [15:0] ct(int n); return cur_count[16*n +: 16]; endfunction
  function automatic logic [5:0] md(int n); return chan_mode[6*n +: 6]; endfunction

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 mask", 16'(chan_mask), 16'hF);
    chk("R1 addr", ad(0), 0);
    chk("R1 cmd", 16'(ctl_word), 0);
    rd8(4'h8, s); chk("R1 status", 16'(s), 0);
    wr16(4'h0, 16'h1234); chk("R1 ptr low first", ad(0), 16'h1234);
  endtask

  task automatic t_load();
    logic [7:0] lo, hi;
    wr8(4'hC, 0);
    wr16(4'h4, 16'hBEEF); wr16(4'h5, 16'h0005);
    chk("R3 ch2 addr", ad(2), 16'hBEEF);
    chk("R3 ch2 count", ct(2), 16'h0005);
    wr16(4'h6, 16'hCAFE);
    chk("R3 ch3 addr", ad(3), 16'hCAFE);
    chk("R3 ch2 untouched", ad(2), 16'hBEEF);
    rd8(4'h4, lo); rd8(4'h4, hi);
    chk("R3 readback", {hi, lo}, 16'hBEEF);
  endtask

  task automatic t_ptr();
    logic [7:0] lo;
    wr8(4'h0, 8'h11); wr8(4'hC, 8'h5A); wr16(4'h0, 16'h3322);
    chk("R2 clear realign", ad(0), 16'h3322);
    rd8(4'h0, lo); wr8(4'h0, 8'h99);
    chk("R2 read toggles", ad(0), 16'h9922);
  endtask

  task automatic t_mask();
    wr8(4'hA, 8'h00); chk("R4 unmask ch0", 16'(chan_mask), 16'hE);
    wr8(4'hA, 8'h02); chk("R4 unmask ch2", 16'(chan_mask), 16'hA);
    wr8(4'hA, 8'h04); chk("R4 mask ch0", 16'(chan_mask), 16'hB);
    wr8(4'hE, 8'hFF); chk("R4 clear all", 16'(chan_mask), 16'h0);
    wr8(4'hF, 8'h05); chk("R4 write all", 16'(chan_mask), 16'h5);
  endtask

  task automatic t_mode();
    wr8(4'hB, 8'h45); chk("R5 mode ch1", 16'(md(1)), 16'h11);
    wr8(4'hB, 8'hC2); chk("R5 mode ch2", 16'(md(2)), 16'h30);
    chk("R5 ch0 untouched", 16'(md(0)), 16'h00);
  endtask

  task automatic t_advance();
    wr8(4'hC, 0);
    wr16(4'h0, 16'h1000); wr16(4'h1, 16'h0002);
    wr8(4'hB, 8'h44); wr8(4'hA, 8'h00);
    pulse(4'h1);
    chk("R6 inc addr", ad(0), 16'h1001);
    chk("R6 count", ct(0), 16'h0001);
    wr16(4'h2, 16'h2000); wr16(4'h3, 16'h0005);
    wr8(4'hB, 8'h69); wr8(4'hA, 8'h01);
    pulse(4'h2);
    chk("R6 dec addr", ad(1), 16'h1FFF);
    chk("R6 dec count", ct(1), 16'h0004);
  endtask

  task automatic t_masked();
    wr8(4'hA, 8'h05); pulse(4'h2);
    chk("R7 addr held", ad(1), 16'h1FFF);
    chk("R7 count held", ct(1), 16'h0004);
  endtask

  task automatic t_tc();
    logic [7:0] s, lo, hi;
    pulse(4'h1); pulse(4'h1);
    chk("R8 wrap count", ct(0), 16'hFFFF);
    chk("R8 addr", ad(0), 16'h1003);
    rd8(4'h8, s); chk("R8 status tc0", 16'(s), 16'h01);
    rd8(4'h8, s); chk("R8 read clears", 16'(s), 16'h00);
    wr8(4'hC, 0); rd8(4'h1, lo); rd8(4'h1, hi);
    chk("R8 count port", {hi, lo}, 16'hFFFF);
  endtask

  task automatic t_autoinit();
    logic [7:0] s;
    wr8(4'hC, 0);
    wr16(4'h6, 16'h4000); wr16(4'h7, 16'h0001);
    wr8(4'hB, 8'h57); wr8(4'hA, 8'h03);
    pulse(4'h8);
    chk("R9 first step", ad(3), 16'h4001);
    pulse(4'h8);
    chk("R9 addr reload", ad(3), 16'h4000);
    chk("R9 count reload", ct(3), 16'h0001);
    rd8(4'h8, s); chk("R9 status tc3", 16'(s), 16'h08);
  endtask

  task automatic t_request();
    logic [7:0] s;
    wr8(4'h9, 8'h06); rd8(4'h8, s); chk("R10 req set", 16'(s), 16'h40);
    wr8(4'h9, 8'h02); rd8(4'h8, s); chk("R10 req clr", 16'(s), 16'h00);
  endtask

  task automatic t_priority();
    wr8(4'hC, 0);
    @(negedge clk); bus_addr = 4'h0; bus_wdata = 8'h77; bus_wr = 1; advance = 4'h1;
    @(negedge clk); bus_wr = 0; advance = 0;
    chk("R13 write wins addr", ad(0), 16'h1077);
    chk("R13 count held", ct(0), 16'hFFFF);
  endtask

  task automatic t_cmd();
    logic [7:0] s;
    wr8(4'h8, 8'h5A); chk("R12 ctl word", 16'(ctl_word), 16'h5A);
    rd8(4'hD, s); chk("R12 temp read", 16'(s), 16'h00);
  endtask

  task automatic t_mclr();
    logic [7:0] s;
    wr8(4'h9, 8'h05); wr8(4'hE, 0); wr8(4'h0, 8'h12);
    wr8(4'hD, 8'h00);
    chk("R11 mask set", 16'(chan_mask), 16'hF);
    chk("R11 cmd zero", 16'(ctl_word), 16'h00);
    rd8(4'h8, s); chk("R11 status zero", 16'(s), 16'h00);
    chk("R11 mode kept", 16'(md(1)), 16'h1A);
    chk("R11 addr kept", ad(2), 16'hBEEF);
    wr16(4'h0, 16'hBBAA); chk("R11 ptr low", ad(0), 16'hBBAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_load(); t_ptr(); t_mask(); t_mode(); t_advance();
    t_masked(); t_tc(); t_autoinit(); t_request(); t_priority();
    t_cmd(); t_mclr();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule